// File: doc/BRIEF.md
# Multi-port GPIO pad controller

This block is a register-mapped general-purpose I/O controller built from identical ports of eight pins each. The number of ports is a parameter of at most seven. Each port has a data-output register, a data-input register holding the sampled pad levels, a drive-mode register with a 2-bit field per pin, and a pull-up register in which a set bit turns that pin's pull-up off. For every pin the block drives three pad signals: an output value, an output enable and a pull-up enable. The drive-mode field selects input, push-pull, open-drain or open-source behaviour.

A global control register, which holds no pin data, sits at the bottom of the address space. Two of its bits are writable: a block enable and an input-synchronizer select. The rest of its low half reports the port count and a version number, so software can find out the size of the block. While the block enable is low, writes to the port registers have no effect and the pad inputs are not sampled. Reads go through a simple strobe interface, and the read data is registered one cycle after the read strobe.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After synchronous reset, every pin has output enable 0, output value 0 and pull-up enable 1. The control register reads {ports, version, sync=0, enable=0}.
- R2: The control register is at byte address 0x00. Bit 0 (block enable) and bit 1 (synchronizer select) are writable. Bits 8:2 read VERSION_ID and bits 15:9 read NUM_PORTS. Writes do not change these read-only fields, and bits 31:16 read 0.
- R3: While the block enable is 0, writes to any port register leave that register unchanged.
- R4: Port p (0-based) occupies byte addresses 0x10*(p+1) to 0x10*(p+1)+0xF. Its registers sit at offsets 0x0 (data input, read-only), 0x4 (data output), 0x8 (drive mode; pin n uses bits [2n+1:2n]) and 0xC (pull-up disable). Pin n of port p is pad bit 8p+n. An access whose address bits [1:0] are not 00 is ignored, and so is an access to a port number above NUM_PORTS. Reads of such addresses return 0.
- R5: Drive mode 00 (input) gives output enable 0 and output value 0, whatever the data-output bit holds.
- R6: Drive mode 01 (push-pull) gives output enable 1, with the output value equal to the data-output bit.
- R7: Drive mode 10 (open-drain) gives output value 0, with output enable equal to the inverse of the data-output bit.
- R8: Drive mode 11 (open-source) gives output value 1, with output enable equal to the data-output bit.
- R9: A pin's pull-up enable is the inverse of its bit in the pull-up disable register.
- R10: A read returns its data on rdata on the cycle after rd_en. With the synchronizer select at 0, the data-input register takes a pad level at the first clock edge after the level appears. With the select at 1, it takes the level at the second edge.
- R11: While the block enable is 0, the data-input register keeps its value (0 after reset) whatever the pads do.
- R12: Register reads return 0 above the field width: above bit 7 for data input, data output and pull-up, and above bit 15 for drive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write data (no writable field lies above bit 15) |
| rdata | output | 32 | Registered read data |
| pad_in | input | 8*NUM_PORTS | Pad input levels |
| pad_out | output | 8*NUM_PORTS | Pad output values |
| pad_oe | output | 8*NUM_PORTS | Pad output enables |
| pad_pu_en | output | 8*NUM_PORTS | Pad pull-up enables |

## Verification
The hardest behaviour to show from the ports is input latency. The difference between one and two sampling stages can only be seen by holding a read strobe on the data-input register over several cycles around a pad change. The bench does this for both synchronizer settings and compares the cycle in which the new level first appears on rdata. The gated state before enable needs care as well: the bench writes every kind of port register and toggles the pads while the enable is low, then reads each register back before it sets the enable. The drive modes are covered by directed patterns that put all four modes side by side within one port, and then by random register writes checked pin by pin against a reference model of the pad signals.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int PINS_PER_PORT = 8;
    localparam int WIN_SHIFT     = 4;

    typedef enum logic [1:0] {
        DRV_INPUT  = 2'b00,
        DRV_PUSH   = 2'b01,
        DRV_SINK   = 2'b10,
        DRV_SOURCE = 2'b11
    } drv_mode_e;

    typedef enum logic [1:0] {
        OFS_DIN  = 2'd0,
        OFS_DOUT = 2'd1,
        OFS_MODE = 2'd2,
        OFS_PDIS = 2'd3
    } port_ofs_e;

    typedef struct packed {
        logic val;
        logic oe;
    } pad_drv_t;

    function automatic pad_drv_t drive_of(input drv_mode_e m, input logic d);
        pad_drv_t r;
        case (m)
            DRV_PUSH:   begin r.val = d;    r.oe = 1'b1; end
            DRV_SINK:   begin r.val = 1'b0; r.oe = ~d;   end
            DRV_SOURCE: begin r.val = 1'b1; r.oe = d;    end
            default:    begin r.val = 1'b0; r.oe = 1'b0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
    import gpio_pad_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       dout,
    input  logic       pull_dis,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pad_pu_en
);
    pad_drv_t drv;

    always_comb begin
        drv       = drive_of(drv_mode_e'(mode), dout);
        pad_out   = drv.val;
        pad_oe    = drv.oe;
        pad_pu_en = ~pull_dis;
    end
endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
    parameter int       NUM_PORTS  = 7,
    parameter bit [6:0] VERSION_ID = 7'h13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic [1:0]  wbits,
    output logic        blk_en,
    output logic        sync_en,
    output logic [31:0] ctrl_word
);
    localparam logic [6:0] PORT_FIELD = 7'(NUM_PORTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_en  <= 1'b0;
            sync_en <= 1'b0;
        end else if (wr_stb) begin
            blk_en  <= wbits[0];
            sync_en <= wbits[1];
        end
    end

    always_comb begin
        ctrl_word = {16'h0000, PORT_FIELD, VERSION_ID, sync_en, blk_en};
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pad_pkg::*;
#(
    localparam int NP = PINS_PER_PORT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_en,
    input  logic          sync_en,
    input  logic          wr_stb,
    input  port_ofs_e     wr_ofs,
    input  logic [15:0]   wdata,
    input  logic [NP-1:0] pad_in,
    output logic [NP-1:0] din_q,
    output logic [NP-1:0] dout_q,
    output logic [2*NP-1:0] mode_q,
    output logic [NP-1:0] pdis_q,
    output logic [NP-1:0] pad_out,
    output logic [NP-1:0] pad_oe,
    output logic [NP-1:0] pad_pu_en
);
    logic          wr_ok;
    logic [NP-1:0] stage1_q;
    logic [NP-1:0] din_next;

    always_comb begin
        wr_ok    = wr_stb & blk_en;
        din_next = sync_en ? stage1_q : pad_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            mode_q <= '0;
            pdis_q <= '0;
        end else if (wr_ok) begin
            case (wr_ofs)
                OFS_DOUT: dout_q <= wdata[NP-1:0];
                OFS_MODE: mode_q <= wdata[2*NP-1:0];
                OFS_PDIS: pdis_q <= wdata[NP-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            din_q    <= '0;
        end else if (blk_en) begin
            stage1_q <= pad_in;
            din_q    <= din_next;
        end
    end

    for (genvar n = 0; n < NP; n++) begin : g_pin
        gpio_pin_drv u_pin (
            .mode      (mode_q[2*n +: 2]),
            .dout      (dout_q[n]),
            .pull_dis  (pdis_q[n]),
            .pad_out   (pad_out[n]),
            .pad_oe    (pad_oe[n]),
            .pad_pu_en (pad_pu_en[n])
        );
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int       NUM_PORTS  = 7,
    parameter bit [6:0] VERSION_ID = 7'h13,
    parameter int       ADDR_W     = 8,
    localparam int      NPINS      = NUM_PORTS * PINS_PER_PORT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu_en
);
    localparam int SEL_W = ADDR_W - WIN_SHIFT;
    localparam int NP    = PINS_PER_PORT;

    logic [SEL_W-1:0] sel;
    port_ofs_e        ofs;
    logic             aligned;
    logic             blk_en;
    logic             sync_en;
    logic [31:0]      ctrl_word;
    logic             ctrl_wr;
    logic [31:0]      rd_word;

    logic [NPINS-1:0]   din_all;
    logic [NPINS-1:0]   dout_all;
    logic [2*NPINS-1:0] mode_all;
    logic [NPINS-1:0]   pdis_all;

    always_comb begin
        sel     = addr[ADDR_W-1:WIN_SHIFT];
        ofs     = port_ofs_e'(addr[3:2]);
        aligned = (addr[1:0] == 2'b00);
        ctrl_wr = wr_en && aligned && (sel == '0) && (ofs == OFS_DIN);
    end

    gpio_ctrl_reg #(
        .NUM_PORTS  (NUM_PORTS),
        .VERSION_ID (VERSION_ID)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (ctrl_wr),
        .wbits     (wdata[1:0]),
        .blk_en    (blk_en),
        .sync_en   (sync_en),
        .ctrl_word (ctrl_word)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(p + 1);
        logic port_wr;

        always_comb port_wr = wr_en && aligned && (sel == MY_SEL);

        gpio_port u_port (
            .clk       (clk),
            .rst       (rst),
            .blk_en    (blk_en),
            .sync_en   (sync_en),
            .wr_stb    (port_wr),
            .wr_ofs    (ofs),
            .wdata     (wdata),
            .pad_in    (pad_in[p*NP +: NP]),
            .din_q     (din_all[p*NP +: NP]),
            .dout_q    (dout_all[p*NP +: NP]),
            .mode_q    (mode_all[2*p*NP +: 2*NP]),
            .pdis_q    (pdis_all[p*NP +: NP]),
            .pad_out   (pad_out[p*NP +: NP]),
            .pad_oe    (pad_oe[p*NP +: NP]),
            .pad_pu_en (pad_pu_en[p*NP +: NP])
        );
    end

    always_comb begin
        rd_word = '0;
        if (aligned) begin
            if (sel == '0) begin
                if (ofs == OFS_DIN) rd_word = ctrl_word;
            end else begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (sel == SEL_W'(p + 1)) begin
                        case (ofs)
                            OFS_DIN:  rd_word = {24'h0, din_all[p*NP +: NP]};
                            OFS_DOUT: rd_word = {24'h0, dout_all[p*NP +: NP]};
                            OFS_MODE: rd_word = {16'h0, mode_all[2*p*NP +: 2*NP]};
                            default:  rd_word = {24'h0, pdis_all[p*NP +: NP]};
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
    parameter int NPINS = 56
) (
    input logic               clk,
    input logic               rst,
    input logic               blk_en,
    input logic [NPINS-1:0]   dout_all,
    input logic [2*NPINS-1:0] mode_all,
    input logic [NPINS-1:0]   pdis_all,
    input logic [NPINS-1:0]   pad_out,
    input logic [NPINS-1:0]   pad_oe,
    input logic [NPINS-1:0]   pad_pu_en
);
    a_r3_gated_writes: assert property (@(posedge clk) disable iff (rst)
        !$past(blk_en) |-> ($stable(dout_all) && $stable(mode_all) && $stable(pdis_all)));

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        a_r5_input_released: assert property (@(posedge clk) disable iff (rst)
            (mode_all[2*n +: 2] == 2'b00) |-> (!pad_oe[n] && !pad_out[n]));
        a_r6_push_pull: assert property (@(posedge clk) disable iff (rst)
            (mode_all[2*n +: 2] == 2'b01) |-> (pad_oe[n] && (pad_out[n] == dout_all[n])));
        a_r7_open_drain: assert property (@(posedge clk) disable iff (rst)
            (mode_all[2*n +: 2] == 2'b10) |-> (!pad_out[n] && (pad_oe[n] == !dout_all[n])));
        a_r8_open_source: assert property (@(posedge clk) disable iff (rst)
            (mode_all[2*n +: 2] == 2'b11) |-> (pad_out[n] && (pad_oe[n] == dout_all[n])));
        a_r9_pull_inverse: assert property (@(posedge clk) disable iff (rst)
            pad_pu_en[n] != pdis_all[n]);
    end
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .blk_en    (blk_en),
    .dout_all  (dout_all),
    .mode_all  (mode_all),
    .pdis_all  (pdis_all),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu_en (pad_pu_en)
);

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb;
    localparam int NPORT = 7;
    localparam int NPINS = NPORT * 8;
    localparam logic [31:0] CTRL_RST = 32'h0000_0E4C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [7:0]        addr = '0;
    logic [15:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NPINS-1:0]  pad_in = '0;
    logic [NPINS-1:0]  pad_out;
    logic [NPINS-1:0]  pad_oe;
    logic [NPINS-1:0]  pad_pu_en;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_dout [NPORT];
    logic [15:0] m_mode [NPORT];
    logic [7:0]  m_pdis [NPORT];

    gpio_pad_ctrl #(.NUM_PORTS(NPORT), .VERSION_ID(7'h13), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu_en(pad_pu_en)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [7:0] pbase(input int p);
        return 8'((p + 1) * 16);
    endfunction

    function automatic logic exp_oe(input logic [1:0] m, input logic d);
        case (m)
            2'b01: return 1'b1;
            2'b10: return ~d;
            2'b11: return d;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_out(input logic [1:0] m, input logic d);
        case (m)
            2'b01: return d;
            2'b11: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic mwrite(input int p, input int ofs, input logic [15:0] d);
        bus_write(pbase(p) + 8'(ofs * 4), d);
        case (ofs)
            1: m_dout[p] = d[7:0];
            2: m_mode[p] = d;
            3: m_pdis[p] = d[7:0];
            default: ;
        endcase
    endtask

    task automatic check_pads(input string tag);
        logic [NPINS-1:0] eo, ev, ep;
        for (int p = 0; p < NPORT; p++) begin
            for (int n = 0; n < 8; n++) begin
                eo[p*8+n] = exp_oe(m_mode[p][2*n +: 2], m_dout[p][n]);
                ev[p*8+n] = exp_out(m_mode[p][2*n +: 2], m_dout[p][n]);
                ep[p*8+n] = ~m_pdis[p][n];
            end
        end
        check({tag, " oe"}, 64'(pad_oe), 64'(eo));
        check({tag, " out"}, 64'(pad_out), 64'(ev));
        check({tag, " pu"}, 64'(pad_pu_en), 64'(ep));
    endtask

    task automatic latency_probe(input logic sync, input string tag);
        logic [31:0] r;
        bus_write(8'h00, {14'h0, sync, 1'b1});
        @(negedge clk);
        pad_in[3*8 +: 8] = 8'h00;
        repeat (4) @(negedge clk);
        pad_in[3*8 +: 8] = 8'h96;
        addr = pbase(3); rd_en = 1'b1;
        @(negedge clk);
        check({tag, " cycle1"}, 64'(rdata), 64'h0);
        @(negedge clk);
        check({tag, " cycle2"}, 64'(rdata), sync ? 64'h0 : 64'h96);
        @(negedge clk);
        check({tag, " cycle3"}, 64'(rdata), 64'h96);
        rd_en = 1'b0;
        bus_read(pbase(3), r);
    endtask

    initial begin
        logic [31:0] r;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int p = 0; p < NPORT; p++) begin
            m_dout[p] = '0; m_mode[p] = '0; m_pdis[p] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check_pads("R1 reset pads");
        bus_read(8'h00, r);
        check("R1 reset control", 64'(r), 64'(CTRL_RST));

        // R3: writes while disabled leave registers at reset
        bus_write(pbase(0) + 8'h4, 16'h00FF);
        bus_write(pbase(0) + 8'h8, 16'h5555);
        bus_write(pbase(0) + 8'hC, 16'h00FF);
        bus_read(pbase(0) + 8'h4, r); check("R3 dout gated", 64'(r), 64'h0);
        bus_read(pbase(0) + 8'h8, r); check("R3 mode gated", 64'(r), 64'h0);
        bus_read(pbase(0) + 8'hC, r); check("R3 pull gated", 64'(r), 64'h0);
        check_pads("R3 pads gated");

        // R11: input not sampled while disabled
        pad_in = {NPINS{1'b1}};
        repeat (5) @(negedge clk);
        bus_read(pbase(0), r);
        check("R11 din frozen", 64'(r), 64'h0);
        pad_in = '0;

        // R2: control fields
        bus_write(8'h00, 16'hFFFF);
        bus_read(8'h00, r);
        check("R2 control all ones", 64'(r), 64'(CTRL_RST | 32'h3));
        bus_write(8'h00, 16'h0001);
        bus_read(8'h00, r);
        check("R2 control enable only", 64'(r), 64'(CTRL_RST | 32'h1));

        // R4 and R12: map, alignment, widths
        mwrite(2, 1, 16'hFF3C);
        bus_read(pbase(2) + 8'h4, r); check("R12 dout width", 64'(r), 64'h3C);
        mwrite(2, 3, 16'hAB00);
        bus_read(pbase(2) + 8'hC, r); check("R12 pull width", 64'(r), 64'h0);
        bus_write(pbase(2) + 8'h5, 16'h0077);
        bus_read(pbase(2) + 8'h4, r); check("R4 misaligned write ignored", 64'(r), 64'h3C);
        bus_read(pbase(2) + 8'h5, r); check("R4 misaligned read zero", 64'(r), 64'h0);
        bus_read(8'h80, r); check("R4 unmapped port reads zero", 64'(r), 64'h0);
        bus_read(8'h04, r); check("R4 control window hole", 64'(r), 64'h0);
        mwrite(6, 2, 16'hFFFF);
        bus_read(pbase(6) + 8'h8, r); check("R4 last port mode", 64'(r), 64'hFFFF);
        check("R4 last port pins drive", 64'(pad_out[55:48]), 64'hFF);
        check_pads("R4 pads after map tests");

        // R5 R6 R7 R8: all four modes side by side in port 1
        mwrite(1, 2, 16'hE4E4);
        mwrite(1, 1, 16'h0000);
        check("R5 input pins oe (dout 0)", 64'({pad_oe[12], pad_oe[8]}), 64'h0);
        check("R6 push-pull dout 0", 64'({pad_oe[9], pad_out[9]}), 64'h2);
        check("R7 open-drain dout 0", 64'({pad_oe[10], pad_out[10]}), 64'h2);
        check("R8 open-source dout 0", 64'({pad_oe[11], pad_out[11]}), 64'h1);
        mwrite(1, 1, 16'h00FF);
        check("R5 input pins oe (dout 1)", 64'({pad_oe[12], pad_out[8]}), 64'h0);
        check("R6 push-pull dout 1", 64'({pad_oe[9], pad_out[9]}), 64'h3);
        check("R7 open-drain dout 1", 64'({pad_oe[10], pad_out[10]}), 64'h0);
        check("R8 open-source dout 1", 64'({pad_oe[11], pad_out[11]}), 64'h3);

        // R9: pull-up inverse
        mwrite(1, 3, 16'h000F);
        check("R9 pull-up port1", 64'(pad_pu_en[15:8]), 64'hF0);

        // R10: input latency, both settings
        latency_probe(1'b0, "R10 direct");
        latency_probe(1'b1, "R10 synced");

        // Random register traffic: R5 R6 R7 R8 R9
        bus_write(8'h00, 16'h0001);
        for (int i = 0; i < 60; i++) begin
            int p, o;
            p = int'($urandom_range(NPORT - 1, 0));
            o = int'($urandom_range(3, 1));
            mwrite(p, o, 16'($urandom));
            check_pads("R6/R7/R8/R9 random pads");
        end

        // Random input sampling: R10
        for (int i = 0; i < 20; i++) begin
            int p;
            logic s;
            s = 1'($urandom);
            p = int'($urandom_range(NPORT - 1, 0));
            bus_write(8'h00, {14'h0, s, 1'b1});
            pad_in = {$urandom, $urandom};
            repeat (3) @(negedge clk);
            bus_read(pbase(p), r);
            check("R10 random din", 64'(r), 64'(pad_in[p*8 +: 8]));
        end

        // R3 again: disable and write, registers hold
        bus_write(8'h00, 16'h0000);
        bus_write(pbase(4) + 8'h4, ~{8'h0, m_dout[4]});
        bus_read(pbase(4) + 8'h4, r);
        check("R3 dout held after disable", 64'(r), 64'(m_dout[4]));
        check_pads("R3 pads held after disable");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule